// File: doc/BRIEF.md
# Modem Status Change Detector

This block watches the four active-low modem handshake inputs of a serial port: clear-to-send, data-set-ready, ring indicator and carrier detect. Each input is brought into the clock domain through a synchronizer chain. Edges are then found on the synchronized level. A detected event sets a sticky flag in the low nibble of an 8-bit status word, and the current asserted state of each line appears in the high nibble.

Software reads the status word by pulsing a read strobe. The read returns the flags as they stood before the strobe and clears them on the same clock edge. An event found in the read cycle itself is not lost: it survives into the next read. While any flag is set, an interrupt request is raised, provided the interrupt enable is high.

Top module: `msd_top`

## Requirements
- R1: After reset, rd_data[3:0] reads 0 and irq is 0.
- R2: A change of cts_n in either direction sets rd_data bit 0.
- R3: A change of dsr_n in either direction sets rd_data bit 1.
- R4: ri_n going from 0 (asserted) to 1 (released) sets rd_data bit 2. ri_n going from 1 to 0 leaves bit 2 at 0.
- R5: A change of dcd_n in either direction sets rd_data bit 3.
- R6: rd_data bits 4, 5, 6 and 7 show the inverted synchronized levels of cts_n, dsr_n, ri_n and dcd_n. Each bit follows a pin change SYNC_STAGES clocks later. The matching flag follows one clock after that.
- R7: A flag stays at 1 until a read, even when the pin returns to its earlier level.
- R8: A clock edge with rd_en high clears rd_data[3:0]. The rd_data value in that cycle still shows the flags as they were before the clear.
- R9: An event detected in the same cycle as a read sets its flag again for the next read.
- R10: irq is 1 exactly when irq_en is 1 and any of rd_data[3:0] is 1. Taking irq_en low does not clear any flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready pin, active low, asynchronous |
| ri_n | input | 1 | Ring indicator pin, active low, asynchronous |
| dcd_n | input | 1 | Carrier detect pin, active low, asynchronous |
| rd_en | input | 1 | Status read strobe; clears the flags at the clock edge |
| rd_data | output | 8 | Status word: flags in [3:0], line states in [7:4] |
| irq_en | input | 1 | Modem status interrupt enable |
| irq | output | 1 | Modem status interrupt request |

## Verification
The bench builds the block with the default SYNC_STAGES of 2. It derives its sampling points from that value: a level change shows on the status bits two clocks after the pin moves, and the flag shows one clock later. Because that latency is known, the bench can place a read strobe in exactly the cycle where an event is being detected. This brings the collision rule of R9 within reach, together with the one-sided ring-indicator rule of R4.

// File: rtl/msd_pkg.sv
package msd_pkg;

  localparam int LINE_CNT = 4;
  localparam int STAT_W   = 2 * LINE_CNT;

  localparam int L_CTS = 0;
  localparam int L_DSR = 1;
  localparam int L_RI  = 2;
  localparam int L_DCD = 3;

  typedef logic [LINE_CNT-1:0] line_vec_t;

  // Event per line from previous and current synchronized active-low levels.
  // The ring line only reports its release (0 -> 1); the others report any change.
  function automatic line_vec_t line_events(input line_vec_t prev_n, input line_vec_t cur_n);
    line_vec_t ev;
    ev        = prev_n ^ cur_n;
    ev[L_RI]  = ~prev_n[L_RI] & cur_n[L_RI];
    return ev;
  endfunction

  // Flag next-state: a read clears the old flags but keeps new events.
  function automatic line_vec_t flag_next(input line_vec_t cur, input line_vec_t ev,
                                          input logic rd);
    return rd ? ev : (cur | ev);
  endfunction

  function automatic logic [STAT_W-1:0] pack_status(input line_vec_t flags,
                                                    input line_vec_t lvl_n);
    return {~lvl_n, flags};
  endfunction

endpackage

// File: rtl/msd_sync.sv
module msd_sync #(
  parameter int STAGES  = 2,
  parameter int WIDTH   = 4,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= d_async;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= stg[s-1];
      end
      a_r6_chain_shift: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (stg[s] == $past(stg[s-1])));
    end
  end

  assign q_sync = stg[STAGES-1];

endmodule

// File: rtl/msd_delta.sv
module msd_delta
  import msd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  line_vec_t lvl_n,
  input  logic      rd_en,
  output line_vec_t flags,
  output line_vec_t evt
);

  line_vec_t prev_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_n <= '1;
    else        prev_n <= lvl_n;
  end

  assign evt = line_events(prev_n, lvl_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flag_next(flags, evt, rd_en);
  end

  // R7: without a read no flag ever drops
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> ((flags & $past(flags)) == $past(flags)));

  // R8 / R9: after a read only the events of the read cycle remain
  a_r9_read_keeps_new: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (flags == $past(evt)));

  // R2..R5: a detected event always appears as a flag
  a_r2_event_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((flags & $past(evt)) == $past(evt)));

  // R4: the ring flag only rises after the line was released
  a_r4_ring_release_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[L_RI]) |-> $past(!prev_n[L_RI] && lvl_n[L_RI]));

endmodule

// File: rtl/msd_top.sv
module msd_top
  import msd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cts_n,
  input  logic              dsr_n,
  input  logic              ri_n,
  input  logic              dcd_n,
  input  logic              rd_en,
  output logic [STAT_W-1:0] rd_data,
  input  logic              irq_en,
  output logic              irq
);

  line_vec_t pins_n;
  line_vec_t lvl_n;
  line_vec_t flags;
  line_vec_t evt;
  logic      any_flag;

  assign pins_n[L_CTS] = cts_n;
  assign pins_n[L_DSR] = dsr_n;
  assign pins_n[L_RI]  = ri_n;
  assign pins_n[L_DCD] = dcd_n;

  msd_sync #(
    .STAGES  (SYNC_STAGES),
    .WIDTH   (LINE_CNT),
    .RST_VAL ('1)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pins_n),
    .q_sync  (lvl_n)
  );

  msd_delta u_delta (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_n (lvl_n),
    .rd_en (rd_en),
    .flags (flags),
    .evt   (evt)
  );

  assign any_flag = |flags;
  assign rd_data  = pack_status(flags, lvl_n);
  assign irq      = irq_en & any_flag;

  // R10: an interrupt implies a visible flag and an enable
  a_r10_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && (rd_data[LINE_CNT-1:0] != '0)));

  // R10: disabling the interrupt leaves the flags untouched
  a_r10_mask_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en && !rd_en) |=> ((rd_data[3:0] & $past(rd_data[3:0])) == $past(rd_data[3:0])));

endmodule

// File: tb/msd_top_test.sv
module msd_top_test;

  localparam int SYNC_STAGES = 2;
  localparam int LAT_STAT = SYNC_STAGES;
  localparam int LAT_FLAG = SYNC_STAGES + 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
  logic       rd_en = 1'b0;
  logic       irq_en = 1'b0;
  logic [7:0] rd_data;
  logic       irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  msd_top #(.SYNC_STAGES(SYNC_STAGES)) uut (
    .clk(clk), .rst_n(rst_n), .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n),
    .dcd_n(dcd_n), .rd_en(rd_en), .rd_data(rd_data), .irq_en(irq_en), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // status word the bench expects for given flags and pin levels
  function automatic logic [7:0] expect_word(input logic [3:0] f);
    return {~dcd_n, ~ri_n, ~dsr_n, ~cts_n, f};
  endfunction

  // read the word (pre-clear value) and release the strobe
  task automatic do_read(output logic [7:0] got);
    rd_en = 1'b1;
    #1 got = rd_data;
    steps(1);
    rd_en = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] g;
    steps(1);
    check("R1 reset word", rd_data, 8'h00);
    check("R1 reset irq", {7'b0, irq}, 8'h00);
    do_read(g);
    check("R1 read after reset", g, 8'h00);
  endtask

  task automatic t_cts_dsr;
    logic [7:0] g;
    cts_n = 1'b0;
    steps(LAT_STAT);
    check("R6 cts level early", rd_data, expect_word(4'b0000));
    steps(LAT_FLAG - LAT_STAT);
    check("R2 cts fall flag", rd_data, expect_word(4'b0001));
    do_read(g);
    check("R8 read returns pre-clear", g, expect_word(4'b0001));
    check("R8 flags cleared", rd_data, expect_word(4'b0000));
    cts_n = 1'b1;
    dsr_n = 1'b0;
    steps(LAT_FLAG);
    check("R2 R3 cts rise dsr fall", rd_data, expect_word(4'b0011));
    do_read(g);
    dsr_n = 1'b1;
    steps(LAT_FLAG);
    check("R3 dsr rise flag", rd_data, expect_word(4'b0010));
    do_read(g);
  endtask

  task automatic t_ring;
    logic [7:0] g;
    ri_n = 1'b0;
    steps(LAT_FLAG + 1);
    check("R4 ring assert no flag", rd_data, expect_word(4'b0000));
    check("R6 ring level bit", {7'b0, rd_data[6]}, 8'h01);
    ri_n = 1'b1;
    steps(LAT_FLAG);
    check("R4 ring release flag", rd_data, expect_word(4'b0100));
    do_read(g);
  endtask

  task automatic t_dcd_sticky;
    logic [7:0] g;
    dcd_n = 1'b0;
    steps(LAT_FLAG);
    check("R5 dcd fall flag", rd_data, expect_word(4'b1000));
    dcd_n = 1'b1;
    steps(LAT_FLAG + 2);
    check("R7 flag sticky after return", rd_data, expect_word(4'b1000));
    do_read(g);
    check("R5 R8 read after dcd", g, expect_word(4'b1000));
    check("R8 cleared after dcd read", rd_data, 8'h00);
  endtask

  task automatic t_collision;
    logic [7:0] g;
    cts_n = 1'b0;
    steps(LAT_FLAG);
    dsr_n = 1'b0;
    steps(LAT_STAT);   // dsr event is being detected in this cycle
    do_read(g);
    check("R9 read shows old flags only", g & 8'h0F, 8'h01);
    check("R9 new event kept", rd_data, expect_word(4'b0010));
    do_read(g);
    check("R9 second read", rd_data, expect_word(4'b0000));
    cts_n = 1'b1; dsr_n = 1'b1;
    steps(LAT_FLAG);
    do_read(g);
  endtask

  task automatic t_irq;
    logic [7:0] g;
    irq_en = 1'b0;
    dcd_n = 1'b0;
    steps(LAT_FLAG);
    check("R10 masked irq low", {7'b0, irq}, 8'h00);
    check("R10 mask keeps flag", rd_data, expect_word(4'b1000));
    irq_en = 1'b1;
    #1 check("R10 irq with flag", {7'b0, irq}, 8'h01);
    do_read(g);
    #1 check("R10 irq drops after read", {7'b0, irq}, 8'h00);
    dcd_n = 1'b1;
    steps(LAT_FLAG);
    do_read(g);
    irq_en = 1'b0;
  endtask

  initial begin
    steps(3);
    rst_n = 1'b1;
    t_reset();
    t_cts_dsr();
    t_ring();
    t_dcd_sticky();
    t_collision();
    t_irq();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule